// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Pair

This block is the integer multiply and divide unit that sits beside a 32-bit core's main datapath. The core hands it a function code and two operands on a single request strobe. The unit then works on the operation over several cycles. When it finishes, it writes a dedicated pair of result registers, HI and LO, on the same clock edge. A multiply leaves the 64-bit product split across the pair. A divide leaves the quotient in LO and the remainder in HI.

The core uses the same request port to read HI or LO back. If the unit is busy when a read arrives, the unit holds that read. It answers the read on the edge where the running operation completes, so the value returned is always the fresh result. Signed and unsigned variants share one unsigned shift engine. Operands are converted to magnitudes on entry, and the signs are applied again in a final cycle.

Top module: `muldiv_hilo`

## Requirements
- R1: After synchronous reset, `busy` and `rd_valid` are 0, and reads of HI and LO both return 0.
- R2: Function code 0x19 multiplies the operands as unsigned values. HI receives the upper 32 bits of the 64-bit product and LO receives the lower 32 bits.
- R3: Function code 0x18 multiplies the operands as two's-complement values, with the same HI/LO split as R2.
- R4: Function code 0x1B divides `src_a` by `src_b` as unsigned values. LO receives the quotient and HI receives the remainder.
- R5: Function code 0x1A divides as two's-complement values. The quotient is truncated toward zero and the remainder carries the sign of the dividend. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: A divide by zero, signed or unsigned, sets LO to all ones and HI to the dividend, and raises no error.
- R7: An accepted multiply or divide raises `busy` in the cycle after the request edge. `busy` stays high for exactly 33 cycles, and HI and LO both change on the edge where it falls.
- R8: When the unit is idle, a request with code 0x10 (read HI) or 0x12 (read LO) gives `rd_valid` high for one cycle after the request edge, with the selected register on `rd_data`.
- R9: A read requested while `busy` is high gives no `rd_valid` while busy. It is answered in the first cycle after `busy` falls, with the newly written value.
- R10: A multiply or divide request made while `busy` is high is ignored. It changes neither the result nor the time at which `busy` falls.
- R11: A request with any other function code is ignored. `busy` and `rd_valid` stay low, and HI and LO keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled each rising edge |
| func | input | 6 | Function code of the request |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` as a read answer |
| rd_data | output | 32 | Value of HI or LO returned by a read |

## Verification
The hardest case to reach from the ports is a held read, particularly one that overlaps with a second start request during the same operation. To create it, the stimulus issues a long operation and then places a read request one edge after acceptance. In a separate test it injects a competing multiply a few cycles into a run. In each case the bench compares the value returned when `busy` falls against the first operation's result. Signed divides are exercised in all four sign combinations, plus the most-negative-by-minus-one case and divide-by-zero. These cover the sign-restoration stage, which is otherwise unobservable.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam logic [5:0] FN_RD_HI = 6'h10;
  localparam logic [5:0] FN_RD_LO = 6'h12;
  localparam logic [5:0] FN_MUL_S = 6'h18;
  localparam logic [5:0] FN_MUL_U = 6'h19;
  localparam logic [5:0] FN_DIV_S = 6'h1A;
  localparam logic [5:0] FN_DIV_U = 6'h1B;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } mdu_state_t;
endpackage

// File: rtl/muldiv_seq_mul.sv
// Radix-2 shift-add multiplier on unsigned magnitudes, one bit per step.
module muldiv_seq_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] acc_q;
  logic [W:0]     upper_sum;

  assign upper_sum = {1'b0, acc_q[2*W-1:W]} + {1'b0, mcand_q};

  always_ff @(posedge clk) begin
    if (load) begin
      mcand_q <= mcand;
      acc_q   <= {{W{1'b0}}, mplier};
    end else if (step) begin
      if (acc_q[0]) acc_q <= {upper_sum, acc_q[W-1:1]};
      else          acc_q <= {1'b0, acc_q[2*W-1:1]};
    end
  end

  assign prod = acc_q;
endmodule

// File: rtl/muldiv_seq_div.sv
// Restoring divider on unsigned magnitudes, one quotient bit per step.
module muldiv_seq_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  logic [W-1:0] dvs_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] rem_q;
  logic [W:0]   shifted;
  logic [W+1:0] trial;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, dvs_q};

  always_ff @(posedge clk) begin
    if (load) begin
      dvs_q <= divisor;
      quo_q <= dividend;
      rem_q <= '0;
    end else if (step) begin
      if (trial[W+1]) begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end else begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end
    end
  end

  assign quot = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic [5:0]   func,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  import muldiv_pkg::*;

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  mdu_state_t state_q;
  logic [CW-1:0] step_q;
  logic [W-1:0]  hi_q, lo_q;
  logic          is_div_q, neg_prod_q, neg_quo_q, neg_rem_q, div_zero_q;
  logic [W-1:0]  dividend_q;
  logic          pend_q, pend_hi_q;

  logic is_arith, is_read, sel_hi, accept;
  logic signed_op, neg_a, neg_b;
  logic [W-1:0]   mag_a, mag_b;
  logic [2*W-1:0] prod_mag, prod_fix;
  logic [W-1:0]   quo_mag, rem_mag;
  logic [W-1:0]   hi_nx, lo_nx;
  logic           serve_fin, serve_hi_fin;

  assign is_arith  = (func == FN_MUL_S) || (func == FN_MUL_U) ||
                     (func == FN_DIV_S) || (func == FN_DIV_U);
  assign is_read   = (func == FN_RD_HI) || (func == FN_RD_LO);
  assign sel_hi    = (func == FN_RD_HI);
  assign accept    = req && is_arith && (state_q == ST_IDLE);
  assign signed_op = ~func[0];
  assign neg_a     = signed_op & src_a[W-1];
  assign neg_b     = signed_op & src_b[W-1];
  assign mag_a     = neg_a ? (~src_a + 1'b1) : src_a;
  assign mag_b     = neg_b ? (~src_b + 1'b1) : src_b;

  muldiv_seq_mul #(.W(W)) u_mul (
    .clk    (clk),
    .load   (accept),
    .step   (state_q == ST_RUN),
    .mcand  (mag_a),
    .mplier (mag_b),
    .prod   (prod_mag)
  );

  muldiv_seq_div #(.W(W)) u_div (
    .clk      (clk),
    .load     (accept),
    .step     (state_q == ST_RUN),
    .dividend (mag_a),
    .divisor  (mag_b),
    .quot     (quo_mag),
    .rem      (rem_mag)
  );

  // Sign restoration and divide-by-zero override, used in the finish cycle.
  always_comb begin
    prod_fix = neg_prod_q ? (~prod_mag + 1'b1) : prod_mag;
    if (!is_div_q) begin
      hi_nx = prod_fix[2*W-1:W];
      lo_nx = prod_fix[W-1:0];
    end else if (div_zero_q) begin
      hi_nx = dividend_q;
      lo_nx = '1;
    end else begin
      hi_nx = neg_rem_q ? (~rem_mag + 1'b1) : rem_mag;
      lo_nx = neg_quo_q ? (~quo_mag + 1'b1) : quo_mag;
    end
  end

  assign serve_fin    = pend_q || (req && is_read);
  assign serve_hi_fin = (req && is_read) ? sel_hi : pend_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      is_div_q   <= 1'b0;
      neg_prod_q <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      div_zero_q <= 1'b0;
      dividend_q <= '0;
      pend_q     <= 1'b0;
      pend_hi_q  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q    <= ST_RUN;
            step_q     <= '0;
            is_div_q   <= func[1];
            neg_prod_q <= neg_a ^ neg_b;
            neg_quo_q  <= neg_a ^ neg_b;
            neg_rem_q  <= neg_a;
            div_zero_q <= (src_b == '0);
            dividend_q <= src_a;
          end else if (req && is_read) begin
            rd_valid <= 1'b1;
            rd_data  <= sel_hi ? hi_q : lo_q;
          end
        end
        ST_RUN: begin
          step_q <= step_q + 1'b1;
          if (step_q == LAST_STEP) state_q <= ST_FIN;
          if (req && is_read) begin
            pend_q    <= 1'b1;
            pend_hi_q <= sel_hi;
          end
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          hi_q    <= hi_nx;
          lo_q    <= lo_nx;
          pend_q  <= 1'b0;
          if (serve_fin) begin
            rd_valid <= 1'b1;
            rd_data  <= serve_hi_fin ? hi_nx : lo_nx;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       req,
  input logic [5:0] func,
  input logic       busy,
  input logic       rd_valid
);
  localparam int BW = $clog2(W + 2) + 1;
  logic [BW-1:0] busy_cnt;
  logic arith_req, read_req;

  assign arith_req = req && (func[5:2] == 4'b0110);
  assign read_req  = req && ((func == 6'h10) || (func == 6'h12));

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else     busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
  end

  p_start_r7: assert property (@(posedge clk) disable iff (rst)
    (arith_req && !busy) |=> busy);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_cnt < BW'(W)) |=> busy);
  p_end_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_cnt == BW'(W)) |=> !busy);
  p_idle_read_r8: assert property (@(posedge clk) disable iff (rst)
    (read_req && !busy) |=> rd_valid);
  p_no_answer_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rd_valid);
  p_other_code_r11: assert property (@(posedge clk) disable iff (rst)
    (req && !arith_req && !read_req && !busy) |=> (!busy && !rd_valid));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .func     (func),
  .busy     (busy),
  .rd_valid (rd_valid)
);

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req = 1'b0;
  logic [5:0]   func = '0;
  logic [W-1:0] src_a = '0, src_b = '0;
  logic         busy, rd_valid;
  logic [W-1:0] rd_data;
  int checks = 0;
  int errors = 0;

  muldiv_hilo #(.W(W)) uut (
    .clk(clk), .rst(rst), .req(req), .func(func), .src_a(src_a),
    .src_b(src_b), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [5:0] f, input logic [W-1:0] a,
                                input logic [W-1:0] b, output logic [W-1:0] hi,
                                output logic [W-1:0] lo);
    logic [63:0] p;
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      6'h19: begin p = {32'b0, a} * {32'b0, b}; hi = p[63:32]; lo = p[31:0]; end
      6'h18: begin p = sa * sb; hi = p[63:32]; lo = p[31:0]; end
      default: begin
        if (b == 0) begin hi = a; lo = '1; end
        else if (f == 6'h1B) begin hi = a % b; lo = a / b; end
        else begin p = sa % sb; hi = p[31:0]; p = sa / sb; lo = p[31:0]; end
      end
    endcase
  endfunction

  task automatic send(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    req = 1'b1; func = f; src_a = a; src_b = b;
    @(negedge clk);
    req = 1'b0; func = '0;
  endtask

  task automatic read_reg(input bit hi, input logic [W-1:0] exp, input string tag);
    send(hi ? 6'h10 : 6'h12, '0, '0);
    chk(rd_valid == 1'b1, {tag, " rd_valid"}, W'(rd_valid), 1);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy && cycles < 200) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [5:0] f, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
    logic [W-1:0] eh, el;
    int n;
    model(f, a, b, eh, el);
    send(f, a, b);
    wait_idle(n);
    chk(n == W + 1, "R7 busy length", W'(n), W'(W + 1));
    read_reg(1'b1, eh, {tag, " HI"});
    read_reg(1'b0, el, {tag, " LO"});
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy after reset", W'(busy), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", W'(rd_valid), 0);
    read_reg(1'b1, '0, "R1 HI reset");
    read_reg(1'b0, '0, "R1 LO reset");
  endtask

  task automatic t_mul();
    run_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mulu max");
    run_op(6'h19, 32'd123456, 32'd789, "R2 mulu small");
    run_op(6'h18, -32'sd3, 32'sd7, "R3 muls neg*pos");
    run_op(6'h18, 32'h8000_0000, 32'h8000_0000, "R3 muls minneg^2");
    run_op(6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 muls -1*-1");
  endtask

  task automatic t_div();
    run_op(6'h1B, 32'd100, 32'd7, "R4 divu");
    run_op(6'h1B, 32'hFFFF_FFFF, 32'h10, "R4 divu large");
    run_op(6'h1A, -32'sd7, 32'sd2, "R5 divs -/+");
    run_op(6'h1A, 32'sd7, -32'sd2, "R5 divs +/-");
    run_op(6'h1A, -32'sd7, -32'sd2, "R5 divs -/-");
    run_op(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, "R5 divs minneg/-1");
    run_op(6'h1B, 32'd5, 32'd0, "R6 divu by zero");
    run_op(6'h1A, -32'sd5, 32'd0, "R6 divs by zero");
  endtask

  task automatic t_held_read();
    logic [W-1:0] eh, el;
    int n;
    bit early = 1'b0;
    model(6'h19, 32'h1234_5678, 32'h9ABC_DEF0, eh, el);
    send(6'h19, 32'h1234_5678, 32'h9ABC_DEF0);
    send(6'h10, '0, '0);
    n = 0;
    while (busy && n < 200) begin
      if (rd_valid) early = 1'b1;
      n++;
      @(negedge clk);
    end
    chk(!early, "R9 no answer while busy", W'(early), 0);
    chk(rd_valid == 1'b1, "R9 held read answered", W'(rd_valid), 1);
    chk(rd_data == eh, "R9 held read value", rd_data, eh);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R9 single answer", W'(rd_valid), 0);
  endtask

  task automatic t_start_busy();
    logic [W-1:0] eh, el;
    int n;
    model(6'h1B, 32'd1000, 32'd33, eh, el);
    send(6'h1B, 32'd1000, 32'd33);
    @(negedge clk);
    send(6'h19, 32'd77, 32'd88);
    wait_idle(n);
    chk(n == W - 2, "R10 busy end unchanged", W'(n), W'(W - 2));
    read_reg(1'b1, eh, "R10 HI from first op");
    read_reg(1'b0, el, "R10 LO from first op");
  endtask

  task automatic t_other_code();
    send(6'h11, 32'd9, 32'd9);
    chk(busy == 1'b0, "R11 busy stays low", W'(busy), 0);
    chk(rd_valid == 1'b0, "R11 no answer", W'(rd_valid), 0);
    read_reg(1'b0, 32'd30, "R11 LO kept");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mul();
    t_div();
    t_held_read();
    t_start_busy();
    t_other_code();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule